// File: doc/BRIEF.md
# Software-Refilled Translation Buffer

This block holds a small, fully associative set of address translations from virtual pages to physical pages, each tagged with a process identifier, access rights and usage flags. A lookup presents a virtual address, the requesting process and whether the access is a store and whether it comes from user mode. In the same cycle the block returns either a translated physical address with a hit, a protection fault, or a trap request when no valid entry for that page and process is present. The block never reads page tables itself. Trap-handler software resolves the miss and installs the mapping through the install port.

The page offset passes through untranslated. Each hit marks its entry as recently used, and a store hit also marks it as modified. Software can install either at a slot it names or at a slot the block picks. The block prefers the lowest-index empty slot. When every slot is full it uses a rotating pointer that gives a second chance to recently used entries. A single-cycle flush input empties the whole buffer.

The lookup port is accepted on every cycle its valid is high and has no back-pressure. The install port is a valid/ready stream. A beat transfers on a rising edge where both valid and ready are high. Ready drops only during a flush cycle, so an install offered then does not transfer and must be held until ready returns. ENTRIES must be a power of two.

Top module: `swtlb`

## Requirements
- R1: On a hit, `lk_paddr` is the entry's physical page number concatenated with the low 12 bits of `lk_vaddr`, which pass through unchanged. `lk_paddr` and `lk_dirty` are zero when there is no hit.
- R2: With `lk_valid` high, exactly one of `lk_hit`, `lk_fault`, `lk_trap` is high in that same cycle. With `lk_valid` low, all three are low.
- R3: A lookup that matches no valid entry raises `lk_trap` and changes no entry.
- R4: A match requires both the virtual page number and the process identifier to be equal. The same page under another process does not match.
- R5: Every hit sets the matched entry's reference flag, and freshly installed entries start with it clear.
- R6: A store hit sets the entry's dirty flag. `lk_dirty` reports the entry's dirty flag as it stood before the current access.
- R7: Rights bit 0 set means read-only, and bit 1 set means user-accessible. A store to a read-only page, or a user-mode access to a page without bit 1, gives `lk_fault` instead of a hit and updates no flags.
- R8: When several valid entries match, the lowest-index one supplies the translation.
- R9: `flush_all` invalidates every entry at the next edge. `wr_ready` is low during that cycle, and no install takes effect then.
- R10: An install with `wr_use_victim` low writes the slot `wr_index`, replacing what was there.
- R11: An install with `wr_use_victim` high goes to the lowest-index invalid slot if one exists, and the pointer does not move.
- R12: With no invalid slot, a victim install scans from the pointer. It clears and skips entries whose reference flag is set, takes the first clear one, and leaves the pointer one past it.
- R13: After reset every entry is invalid, so every lookup traps, and the pointer is at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_all | input | 1 | Invalidate every entry |
| lk_valid | input | 1 | Lookup request present |
| lk_vaddr | input | 32 | Virtual address |
| lk_pid | input | 8 | Requesting process identifier |
| lk_write | input | 1 | 1 = store, 0 = load |
| lk_user | input | 1 | 1 = user-mode access |
| lk_hit | output | 1 | Translation found and permitted |
| lk_fault | output | 1 | Translation found but access denied |
| lk_trap | output | 1 | No translation; software refill needed |
| lk_paddr | output | 32 | Physical address on a hit |
| lk_dirty | output | 1 | Dirty flag of the hit entry |
| wr_valid | input | 1 | Install beat offered |
| wr_ready | output | 1 | Install beat accepted this cycle |
| wr_use_victim | input | 1 | 1 = block picks the slot, 0 = use wr_index |
| wr_index | input | 4 | Slot for a directed install |
| wr_vpn | input | 20 | Virtual page number to install |
| wr_ppn | input | 20 | Physical page number to install |
| wr_pid | input | 8 | Process identifier to install |
| wr_rights | input | 2 | Access rights (bit 0 read-only, bit 1 user) |
| wr_dirty | input | 1 | Initial dirty flag |

## Verification
The assertions assume the lookup inputs are stable and known through each cycle in which `lk_valid` is high. They also assume an install beat is held until the cycle in which `wr_ready` is high. The dirty and reference checks exclude cycles where an install or a flush overrides the hit's flag update, because those inputs take priority there. The stimulus changes lookup and install inputs only on falling edges. It holds each install through exactly one rising edge outside a flush, except for the one deliberate overlap with a flush that shows the install is dropped.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int RIGHTS_W  = 2;
  localparam int RGT_RONLY = 0;  // store forbidden
  localparam int RGT_USER  = 1;  // user mode allowed

  function automatic logic rights_violation(input logic [RIGHTS_W-1:0] rgt,
                                            input logic is_store,
                                            input logic is_user);
    return (is_store && rgt[RGT_RONLY]) || (is_user && !rgt[RGT_USER]);
  endfunction
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PID_W   = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] valid_i,
  input  logic [VPN_W-1:0]   vpn_i [ENTRIES],
  input  logic [PID_W-1:0]   pid_i [ENTRIES],
  input  logic [VPN_W-1:0]   look_vpn,
  input  logic [PID_W-1:0]   look_pid,
  output logic               any_o,
  output logic [IDX_W-1:0]   idx_o
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [ENTRIES-1:0] hit_vec;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = valid_i[g] && (vpn_i[g] == look_vpn) && (pid_i[g] == look_pid);
  end

  // priority: lowest index wins
  always_comb begin
    idx_o = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) idx_o = IDX_W'(i);
    end
  end
  assign any_o = |hit_vec;

  // R8: no lower-index entry matches the chosen one
  always_comb begin
    for (int j = 0; j < ENTRIES; j++) begin
      if (any_o && (j < int'(idx_o))) begin
        a_r8_lowest_match: assert (!hit_vec[j]);
      end
    end
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] valid_i,
  input  logic [ENTRIES-1:0] ref_i,
  input  logic               advance_i,
  output logic [IDX_W-1:0]   victim_o,
  output logic [ENTRIES-1:0] clr_o,
  output logic               clock_mode_o
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [IDX_W-1:0]   ptr_q;
  logic [IDX_W-1:0]   clk_vic;
  logic [ENTRIES-1:0] clk_clr;
  logic [IDX_W-1:0]   inv_vic;
  logic [IDX_W-1:0]   pos;
  logic               found;

  // second-chance scan starting at the pointer
  always_comb begin
    found   = 1'b0;
    clk_vic = ptr_q;
    clk_clr = '0;
    pos     = '0;
    for (int k = 0; k < ENTRIES; k++) begin
      pos = ptr_q + IDX_W'(k);
      if (!found) begin
        if (ref_i[pos]) clk_clr[pos] = 1'b1;
        else begin
          found   = 1'b1;
          clk_vic = pos;
        end
      end
    end
  end

  // lowest-index empty slot
  always_comb begin
    inv_vic = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_i[i]) inv_vic = IDX_W'(i);
    end
  end

  assign clock_mode_o = &valid_i;
  assign victim_o     = clock_mode_o ? clk_vic : inv_vic;
  assign clr_o        = clock_mode_o ? clk_clr : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          ptr_q <= '0;
    else if (advance_i && clock_mode_o)  ptr_q <= clk_vic + 1'b1;
  end

  // R12: pointer lands just past the chosen victim
  a_r12_ptr_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (advance_i && clock_mode_o) |=> (ptr_q == $past(victim_o) + 1'b1));
  // R11: with empty slots the pointer holds
  a_r11_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (advance_i && !clock_mode_o) |=> $stable(ptr_q));
endmodule

// File: rtl/swtlb.sv
module swtlb
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int OFF_W   = 12,
  parameter int PID_W   = 8,
  localparam int VPN_W  = VA_W - OFF_W,
  localparam int PPN_W  = PA_W - OFF_W,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush_all,
  input  logic                lk_valid,
  input  logic [VA_W-1:0]     lk_vaddr,
  input  logic [PID_W-1:0]    lk_pid,
  input  logic                lk_write,
  input  logic                lk_user,
  output logic                lk_hit,
  output logic                lk_fault,
  output logic                lk_trap,
  output logic [PA_W-1:0]     lk_paddr,
  output logic                lk_dirty,
  input  logic                wr_valid,
  output logic                wr_ready,
  input  logic                wr_use_victim,
  input  logic [IDX_W-1:0]    wr_index,
  input  logic [VPN_W-1:0]    wr_vpn,
  input  logic [PPN_W-1:0]    wr_ppn,
  input  logic [PID_W-1:0]    wr_pid,
  input  logic [RIGHTS_W-1:0] wr_rights,
  input  logic                wr_dirty
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [VPN_W-1:0]    vpn_q [ENTRIES];
  logic [PPN_W-1:0]    ppn_q [ENTRIES];
  logic [PID_W-1:0]    pid_q [ENTRIES];
  logic [RIGHTS_W-1:0] rgt_q [ENTRIES];
  logic [ENTRIES-1:0]  valid_q, ref_q, dirty_q;
  logic [ENTRIES-1:0]  valid_d, ref_d, dirty_d;

  logic               any_match;
  logic [IDX_W-1:0]   m_idx;
  logic               denied;
  logic               install;
  logic               advance;
  logic [IDX_W-1:0]   victim;
  logic [IDX_W-1:0]   tgt;
  logic [ENTRIES-1:0] clr_mask;
  logic               clock_mode;

  tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W)) u_match (
    .valid_i  (valid_q),
    .vpn_i    (vpn_q),
    .pid_i    (pid_q),
    .look_vpn (lk_vaddr[VA_W-1:OFF_W]),
    .look_pid (lk_pid),
    .any_o    (any_match),
    .idx_o    (m_idx)
  );

  tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk          (clk),
    .rst_n        (rst_n),
    .valid_i      (valid_q),
    .ref_i        (ref_q),
    .advance_i    (advance),
    .victim_o     (victim),
    .clr_o        (clr_mask),
    .clock_mode_o (clock_mode)
  );

  // lookup outcome
  assign denied   = rights_violation(rgt_q[m_idx], lk_write, lk_user);
  assign lk_hit   = lk_valid && any_match && !denied;
  assign lk_fault = lk_valid && any_match && denied;
  assign lk_trap  = lk_valid && !any_match;
  assign lk_paddr = lk_hit ? {ppn_q[m_idx], lk_vaddr[OFF_W-1:0]} : '0;
  assign lk_dirty = lk_hit && dirty_q[m_idx];

  // install stream
  assign wr_ready = !flush_all;
  assign install  = wr_valid && wr_ready;
  assign advance  = install && wr_use_victim;
  assign tgt      = wr_use_victim ? victim : wr_index;

  always_comb begin
    valid_d = valid_q;
    ref_d   = ref_q;
    dirty_d = dirty_q;
    if (flush_all) begin
      valid_d = '0;
    end else begin
      if (advance) ref_d = ref_d & ~clr_mask;
      if (lk_hit) begin
        ref_d[m_idx] = 1'b1;
        if (lk_write) dirty_d[m_idx] = 1'b1;
      end
      if (install) begin
        valid_d[tgt] = 1'b1;
        ref_d[tgt]   = 1'b0;
        dirty_d[tgt] = wr_dirty;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      ref_q   <= '0;
      dirty_q <= '0;
    end else begin
      valid_q <= valid_d;
      ref_q   <= ref_d;
      dirty_q <= dirty_d;
    end
  end

  always_ff @(posedge clk) begin
    if (install) begin
      vpn_q[tgt] <= wr_vpn;
      ppn_q[tgt] <= wr_ppn;
      pid_q[tgt] <= wr_pid;
      rgt_q[tgt] <= wr_rights;
    end
  end

  // R2: exactly one outcome per request, none when idle
  a_r2_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> ($countones({lk_hit, lk_fault, lk_trap}) == 1));
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> !(lk_hit || lk_fault || lk_trap));
  // R1: offset bits are untranslated
  a_r1_offset: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]));
  // R5: a hit marks its entry referenced
  a_r5_ref_set: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && !install && !flush_all) |=> ref_q[$past(m_idx)]);
  // R6: a store hit marks its entry dirty
  a_r6_dirty_set: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && lk_write && !install && !flush_all) |=> dirty_q[$past(m_idx)]);
  // R9: flush empties the buffer
  a_r9_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (valid_q == '0));
endmodule

// File: tb/swtlb_test.sv
module swtlb_test;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush_all = 1'b0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic [7:0]  lk_pid = '0;
  logic        lk_write = 1'b0;
  logic        lk_user = 1'b0;
  logic        lk_hit, lk_fault, lk_trap, lk_dirty;
  logic [31:0] lk_paddr;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic        wr_use_victim = 1'b0;
  logic [3:0]  wr_index = '0;
  logic [19:0] wr_vpn = '0;
  logic [19:0] wr_ppn = '0;
  logic [7:0]  wr_pid = '0;
  logic [1:0]  wr_rights = '0;
  logic        wr_dirty = 1'b0;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  swtlb uut (
    .clk(clk), .rst_n(rst_n), .flush_all(flush_all),
    .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_pid(lk_pid),
    .lk_write(lk_write), .lk_user(lk_user),
    .lk_hit(lk_hit), .lk_fault(lk_fault), .lk_trap(lk_trap),
    .lk_paddr(lk_paddr), .lk_dirty(lk_dirty),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_use_victim(wr_use_victim),
    .wr_index(wr_index), .wr_vpn(wr_vpn), .wr_ppn(wr_ppn), .wr_pid(wr_pid),
    .wr_rights(wr_rights), .wr_dirty(wr_dirty)
  );

  typedef struct packed {
    logic [31:0] va;
    logic [7:0]  pid;
    logic        st;
    logic        usr;
    logic [2:0]  res;   // {hit, fault, trap}
    logic [31:0] pa;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{32'h1234_5678, 8'd1, 1'b0, 1'b1, 3'b100, 32'hABCD_E678}, // R1 R4
    '{32'h1234_5ABC, 8'd2, 1'b0, 1'b1, 3'b100, 32'h1111_1ABC}, // R4
    '{32'h1234_5000, 8'd3, 1'b0, 1'b1, 3'b001, 32'h0},         // R3 R4
    '{32'h0040_0010, 8'd1, 1'b0, 1'b1, 3'b100, 32'h2222_2010}, // R7 read ok
    '{32'h0040_0010, 8'd1, 1'b1, 1'b1, 3'b010, 32'h0},         // R7 store ro
    '{32'h8000_0FFF, 8'd1, 1'b0, 1'b1, 3'b010, 32'h0},         // R7 user denied
    '{32'h8000_0FFF, 8'd1, 1'b1, 1'b0, 3'b100, 32'h3333_3FFF}, // R7 supervisor
    '{32'h0077_7123, 8'd3, 1'b0, 1'b0, 3'b100, 32'h4444_4123}, // R8
    '{32'hDEAD_0000, 8'd1, 1'b0, 1'b0, 3'b001, 32'h0},         // R3
    '{32'h1234_5678, 8'd1, 1'b1, 1'b1, 3'b100, 32'hABCD_E678}  // R6 store
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic look(input logic [31:0] va, input logic [7:0] pid,
                      input logic st, input logic usr);
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = va; lk_pid = pid; lk_write = st; lk_user = usr;
    #1;
  endtask

  task automatic look_end;
    @(posedge clk);
    #1 lk_valid = 1'b0;
  endtask

  task automatic put(input logic vic, input logic [3:0] idx, input logic [19:0] vpn,
                     input logic [19:0] ppn, input logic [7:0] pid, input logic [1:0] rgt);
    @(negedge clk);
    wr_valid = 1'b1; wr_use_victim = vic; wr_index = idx; wr_vpn = vpn;
    wr_ppn = ppn; wr_pid = pid; wr_rights = rgt; wr_dirty = 1'b0;
    @(posedge clk);
    #1 wr_valid = 1'b0;
  endtask

  // lookup whose only outcome of interest is hit/fault/trap
  task automatic expect_res(input string req, input logic [31:0] va, input logic [7:0] pid,
                            input logic [2:0] res);
    look(va, pid, 1'b0, 1'b0);
    chk(req, {29'd0, lk_hit, lk_fault, lk_trap}, {29'd0, res});
    look_end();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R13: reset state
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    look(32'h1234_5678, 8'd1, 1'b0, 1'b0);
    chk("R13 reset trap", {29'd0, lk_hit, lk_fault, lk_trap}, 32'd1);
    chk("R13 reset ready", {31'd0, wr_ready}, 32'd1);
    look_end();

    // R10 directed installs
    put(1'b0, 4'd0, 20'h12345, 20'hABCDE, 8'd1, 2'b10);
    put(1'b0, 4'd1, 20'h12345, 20'h11111, 8'd2, 2'b10);
    put(1'b0, 4'd2, 20'h00400, 20'h22222, 8'd1, 2'b11);
    put(1'b0, 4'd3, 20'h80000, 20'h33333, 8'd1, 2'b00);
    put(1'b0, 4'd4, 20'h00777, 20'h44444, 8'd3, 2'b10);
    put(1'b0, 4'd5, 20'h00777, 20'h55555, 8'd3, 2'b10);

    for (int i = 0; i < NV; i++) begin
      look(VEC[i].va, VEC[i].pid, VEC[i].st, VEC[i].usr);
      chk($sformatf("R1/R2/R3/R4/R7/R8 row %0d outcome", i),
          {29'd0, lk_hit, lk_fault, lk_trap}, {29'd0, VEC[i].res});
      chk($sformatf("R1 row %0d paddr", i), lk_paddr, VEC[i].pa);
      chk($sformatf("R6 row %0d prior dirty", i), {31'd0, lk_dirty}, 32'd0);
      look_end();
    end

    // R6: store hit left the page dirty
    look(32'h1234_5000, 8'd1, 1'b0, 1'b1);
    chk("R6 dirty after store", {31'd0, lk_dirty}, 32'd1);
    look_end();
    // R7: faulting store did not mark the read-only page
    look(32'h0040_0000, 8'd1, 1'b0, 1'b1);
    chk("R7 fault no dirty", {31'd0, lk_dirty}, 32'd0);
    look_end();
    // R2: idle lookup port
    #1;
    chk("R2 idle", {29'd0, lk_hit, lk_fault, lk_trap}, 32'd0);

    // R11: victim goes to lowest empty slot (6), proven by overwriting slot 6
    put(1'b1, 4'd0, 20'h00A06, 20'h66666, 8'd7, 2'b10);
    expect_res("R11 victim installed", 32'h00A0_6000, 8'd7, 3'b100);
    put(1'b0, 4'd6, 20'h00B06, 20'h77777, 8'd7, 2'b10);
    expect_res("R11/R10 slot 6 replaced", 32'h00A0_6000, 8'd7, 3'b001);
    expect_res("R10 new mapping", 32'h00B0_6000, 8'd7, 3'b100);
    expect_res("R11 slot 0 kept", 32'h1234_5000, 8'd1, 3'b100);

    // R9: flush, with an install offered in the same cycle
    @(negedge clk);
    flush_all = 1'b1;
    wr_valid = 1'b1; wr_use_victim = 1'b0; wr_index = 4'd7;
    wr_vpn = 20'h00777; wr_ppn = 20'h99999; wr_pid = 8'd5; wr_rights = 2'b10;
    #1 chk("R9 ready low in flush", {31'd0, wr_ready}, 32'd0);
    @(posedge clk);
    #1 begin flush_all = 1'b0; wr_valid = 1'b0; end
    expect_res("R9 flushed entry", 32'h1234_5000, 8'd1, 3'b001);
    expect_res("R9 install dropped", 32'h0077_7000, 8'd5, 3'b001);

    // R12: fill all slots, pointer still at 0
    for (int i = 0; i < 16; i++)
      put(1'b0, 4'(i), 20'h00100 + 20'(i), 20'h00200 + 20'(i), 8'd9, 2'b10);
    expect_res("R5 hit slot0", 32'h0010_0000, 8'd9, 3'b100);
    expect_res("R5 hit slot1", 32'h0010_1000, 8'd9, 3'b100);
    put(1'b1, 4'd0, 20'h00900, 20'h00F00, 8'd9, 2'b10);   // skips 0,1 -> slot 2
    expect_res("R12 slot2 evicted", 32'h0010_2000, 8'd9, 3'b001);
    expect_res("R12 new at slot2", 32'h0090_0000, 8'd9, 3'b100);
    expect_res("R12 slot0 kept", 32'h0010_0000, 8'd9, 3'b100);
    expect_res("R12 slot1 kept", 32'h0010_1000, 8'd9, 3'b100);
    put(1'b1, 4'd0, 20'h00901, 20'h00F01, 8'd9, 2'b10);   // pointer 3 -> slot 3
    expect_res("R12 slot3 evicted", 32'h0010_3000, 8'd9, 3'b001);
    expect_res("R5 hit slot4", 32'h0010_4000, 8'd9, 3'b100);
    expect_res("R5 hit slot5", 32'h0010_5000, 8'd9, 3'b100);
    put(1'b1, 4'd0, 20'h00902, 20'h00F02, 8'd9, 2'b10);   // skips 4,5 -> slot 6
    expect_res("R12 slot6 evicted", 32'h0010_6000, 8'd9, 3'b001);
    expect_res("R12 slot4 kept", 32'h0010_4000, 8'd9, 3'b100);
    expect_res("R12 slot5 kept", 32'h0010_5000, 8'd9, 3'b100);
    expect_res("R12 slot7 kept", 32'h0010_7000, 8'd9, 3'b100);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule